// File: doc/BRIEF.md
# Multi-Toggle Horizontal Blanking Generator

This block produces the horizontal blanking strobe of a CCD timing generator and gates four externally generated horizontal clock phases while blanking is active. A pixel position counter restarts at each line start. Up to three blanking windows per line are each bounded by a pair of 12-bit toggle positions. An alternation mode can split the windows so that the first pair serves lines of one parity and the remaining pairs serve lines of the other parity.

Ten independent configuration sets are stored, one per vertical sequence. The sequence in use is sampled at each line start, so a change to the selector in the middle of a line takes effect only at the next line. While blanking is active, the clock phases are held at a fixed level pattern chosen by a per-sequence mask bit. Outside blanking the phases pass straight through.

Top module: `hblk_gen`

## Requirements
- R1: While reset is held, and after reset until the first line start, `hblank` is 0 and `h_out` equals `h_in`.
- R2: A configuration write stores `cfg_wdata[11:0]` as toggle N+1 of sequence `cfg_seq` when `cfg_addr` is N (0..5). Address 6 stores the mode, with `cfg_wdata[0]` as the mask bit and `cfg_wdata[2:1]` as the alternation mode. Writes with `cfg_seq` of 10 or more, or with address 7, change nothing.
- R3: The pixel position is 0 in the cycle after a line start and then rises by one per cycle, saturating at 4095.
- R4: Toggle pair (a,b) blanks pixel positions p with a <= p < b, and `hblank` shows the result for position p in the following cycle. A pair with a >= b never blanks.
- R5: With alternation mode 0, pairs 1-2, 3-4 and 5-6 all apply on every line.
- R6: With alternation mode 1, only pair 1-2 applies on odd lines, and only pairs 3-4 and 5-6 apply on even lines.
- R7: With alternation mode 2 or 3, only pair 1-2 applies on even lines, and only pairs 3-4 and 5-6 apply on odd lines.
- R8: A line start with `field_start` high makes the line odd. A line start from `line_start` alone flips the parity of the line.
- R9: While `hblank` is high and the mask bit is 1, H1 and H3 (`h_out[0]`, `h_out[2]`) are low and H2 and H4 (`h_out[1]`, `h_out[3]`) are high.
- R10: While `hblank` is high and the mask bit is 0, H1 and H3 are high and H2 and H4 are low.
- R11: While `hblank` is low, `h_out` equals `h_in` in the same cycle.
- R12: `seq_sel` is sampled only at a line start. A value of 10 or more keeps the previous selection, and a change in the middle of a line has no effect on that line.
- R13: `hblank` is 0 in the cycle after any line start, even if it was high before the line start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Horizontal sync; starts a new line |
| field_start | input | 1 | Starts a new line and marks it odd |
| seq_sel | input | 4 | Vertical sequence to use, sampled at line start |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_seq | input | 4 | Sequence targeted by the write |
| cfg_addr | input | 3 | Register within the sequence (0..5 toggles, 6 mode) |
| cfg_wdata | input | 12 | Write data |
| h_in | input | 4 | Free-running clock phases H1..H4 (bit 0 = H1) |
| hblank | output | 1 | Horizontal blanking, active high |
| h_out | output | 4 | Clock phases after blanking gating |

## Verification
Six table vectors each run one odd and one even line. Each vector compares 32 pixel positions of `hblank` in a single check. All four alternation codes run on the same toggle set, so a swapped parity assignment or a mode-3 decoding slip shows up as a wrong window set. Boundary vectors use a window that starts at position 0, a one-pixel window, an empty window with a = b and an inverted window with a > b, which separates off-by-one errors at each edge of a window. A window that ends at 4095 is followed past the end of the counter range, which tells saturation apart from wrap-around. Directed lines drive a run of plain and field line starts and a mid-line change of the selector, and they sample the phase outputs inside and outside blanking for both mask settings.

// File: rtl/hblk_pkg.sv
package hblk_pkg;

    // Line-parity routing of toggle pairs
    typedef enum logic [1:0] {
        ALT_OFF         = 2'd0,
        ALT_ODD_FIRST   = 2'd1,
        ALT_EVEN_FIRST  = 2'd2,
        ALT_EVEN_FIRST2 = 2'd3
    } alt_mode_e;

    // Per-sequence mode word, written from cfg_wdata[2:0]
    typedef struct packed {
        alt_mode_e alt;
        logic      mask;
    } line_mode_t;

    localparam int unsigned CFG_ADDR_W   = 3;
    localparam int unsigned CFG_MODE_IDX = 6;

endpackage

// File: rtl/hblk_cfg_bank.sv
module hblk_cfg_bank
    import hblk_pkg::*;
#(
    parameter int unsigned NSEQ  = 10,
    parameter int unsigned POS_W = 12,
    parameter int unsigned NTOG  = 6,
    parameter int unsigned SEQ_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [SEQ_W-1:0]        wr_seq,
    input  logic [CFG_ADDR_W-1:0]   wr_addr,
    input  logic [POS_W-1:0]        wr_data,
    input  logic [SEQ_W-1:0]        rd_seq,
    output logic [NTOG*POS_W-1:0]   rd_tog,
    output line_mode_t              rd_mode
);

    logic [POS_W-1:0] tog_q [NSEQ][NTOG];
    logic [POS_W-1:0] tog_d [NSEQ][NTOG];
    line_mode_t       mode_q [NSEQ];
    line_mode_t       mode_d [NSEQ];

    always_comb begin
        tog_d  = tog_q;
        mode_d = mode_q;
        if (wr_en) begin
            for (int s = 0; s < NSEQ; s++) begin
                if (int'(wr_seq) == s) begin
                    if (int'(wr_addr) < NTOG) begin
                        tog_d[s][wr_addr] = wr_data;
                    end else if (int'(wr_addr) == CFG_MODE_IDX) begin
                        mode_d[s] = line_mode_t'(wr_data[2:0]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q  <= '{default: '0};
            mode_q <= '{default: '0};
        end else begin
            tog_q  <= tog_d;
            mode_q <= mode_d;
        end
    end

    for (genvar t = 0; t < NTOG; t++) begin : g_rd
        assign rd_tog[t*POS_W +: POS_W] = tog_q[rd_seq][t];
    end

    assign rd_mode = mode_q[rd_seq];

endmodule

// File: rtl/hblk_window.sv
module hblk_window
    import hblk_pkg::*;
#(
    parameter int unsigned POS_W = 12,
    parameter int unsigned NPAIR = 3
) (
    input  logic [POS_W-1:0]         pos,
    input  logic [2*NPAIR*POS_W-1:0] tog,
    input  alt_mode_e                alt,
    input  logic                     odd_line,
    output logic                     in_blank
);

    localparam logic [NPAIR-1:0] FIRST_PAIR = NPAIR'(1);
    localparam logic [NPAIR-1:0] LATER_PAIR = ~FIRST_PAIR;

    logic [NPAIR-1:0] pair_en;
    logic [NPAIR-1:0] pair_hit;

    always_comb begin
        case (alt)
            ALT_OFF:       pair_en = '1;
            ALT_ODD_FIRST: pair_en = odd_line ? FIRST_PAIR : LATER_PAIR;
            default:       pair_en = odd_line ? LATER_PAIR : FIRST_PAIR;
        endcase
    end

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        logic [POS_W-1:0] edge_on;
        logic [POS_W-1:0] edge_off;
        assign edge_on     = tog[(2*k)*POS_W +: POS_W];
        assign edge_off    = tog[(2*k+1)*POS_W +: POS_W];
        assign pair_hit[k] = pair_en[k] && (pos >= edge_on) && (pos < edge_off);
    end

    assign in_blank = |pair_hit;

endmodule

// File: rtl/hblk_phase_gate.sv
module hblk_phase_gate #(
    parameter int unsigned NPH = 4
) (
    input  logic [NPH-1:0] ph_in,
    input  logic           blank,
    input  logic           mask,
    output logic [NPH-1:0] ph_out
);

    // Slots 1,3,.. (H2,H4) park at the mask level, slots 0,2,.. at its inverse
    for (genvar i = 0; i < NPH; i++) begin : g_ph
        localparam bit FOLLOWS_MASK = (i % 2) == 1;
        logic park_lvl;
        assign park_lvl  = FOLLOWS_MASK ? mask : ~mask;
        assign ph_out[i] = blank ? park_lvl : ph_in[i];
    end

endmodule

// File: rtl/hblk_gen.sv
module hblk_gen
    import hblk_pkg::*;
#(
    parameter  int unsigned NSEQ  = 10,
    parameter  int unsigned POS_W = 12,
    parameter  int unsigned NPAIR = 3,
    parameter  int unsigned NPH   = 4,
    localparam int unsigned SEQ_W = $clog2(NSEQ),
    localparam int unsigned NTOG  = 2 * NPAIR
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_start,
    input  logic                  field_start,
    input  logic [SEQ_W-1:0]      seq_sel,
    input  logic                  cfg_we,
    input  logic [SEQ_W-1:0]      cfg_seq,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [POS_W-1:0]      cfg_wdata,
    input  logic [NPH-1:0]        h_in,
    output logic                  hblank,
    output logic [NPH-1:0]        h_out
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             odd;
        logic             blank;
        logic [SEQ_W-1:0] seq;
    } line_state_t;

    line_state_t            st_q;
    line_state_t            st_d;
    logic                   new_line;
    logic                   win_hit;
    logic [POS_W-1:0]       pos_now;
    logic                   odd_now;
    logic                   mask_now;
    logic [NTOG*POS_W-1:0]  cur_tog;
    line_mode_t             cur_mode;

    assign new_line = line_start | field_start;
    assign pos_now  = st_q.pos;
    assign odd_now  = st_q.odd;
    assign mask_now = cur_mode.mask;

    hblk_cfg_bank #(
        .NSEQ  (NSEQ),
        .POS_W (POS_W),
        .NTOG  (NTOG),
        .SEQ_W (SEQ_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_seq  (cfg_seq),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .rd_seq  (st_q.seq),
        .rd_tog  (cur_tog),
        .rd_mode (cur_mode)
    );

    hblk_window #(
        .POS_W (POS_W),
        .NPAIR (NPAIR)
    ) u_win (
        .pos      (pos_now),
        .tog      (cur_tog),
        .alt      (cur_mode.alt),
        .odd_line (odd_now),
        .in_blank (win_hit)
    );

    hblk_phase_gate #(
        .NPH (NPH)
    ) u_gate (
        .ph_in  (h_in),
        .blank  (st_q.blank),
        .mask   (mask_now),
        .ph_out (h_out)
    );

    always_comb begin
        st_d = st_q;
        if (new_line) begin
            st_d.pos   = '0;
            st_d.blank = 1'b0;
            st_d.odd   = field_start ? 1'b1 : ~st_q.odd;
            if (int'(seq_sel) < NSEQ) begin
                st_d.seq = seq_sel;
            end
        end else begin
            if (st_q.pos != POS_MAX) begin
                st_d.pos = st_q.pos + 1'b1;
            end
            st_d.blank = win_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pos: POS_MAX, odd: 1'b1, blank: 1'b0, seq: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hblank = st_q.blank;

endmodule

// File: rtl/hblk_gen_chk.sv
module hblk_gen_chk #(
    parameter int unsigned POS_W = 12,
    parameter int unsigned NPH   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_start,
    input logic             field_start,
    input logic             hblank,
    input logic [NPH-1:0]   h_in,
    input logic [NPH-1:0]   h_out,
    input logic [POS_W-1:0] pos,
    input logic             odd,
    input logic             mask
);

    function automatic logic [NPH-1:0] high_slots();
        logic [NPH-1:0] r;
        r = '0;
        for (int i = 0; i < NPH; i++) begin
            if ((i % 2) == 1) r[i] = 1'b1;
        end
        return r;
    endfunction

    localparam logic [NPH-1:0] PARK_MASK1 = high_slots();
    localparam logic [POS_W-1:0] PMAX = '1;

    logic any_start;
    assign any_start = line_start | field_start;

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !hblank |-> (h_out == h_in));                                   // R11
    AST_PARK_MASK_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank && mask) |-> (h_out == PARK_MASK1));                    // R9
    AST_PARK_MASK_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank && !mask) |-> (h_out == ~PARK_MASK1));                  // R10
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |=> !hblank);                                         // R13
    AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        any_start |=> (pos == '0));                                     // R3
    AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_start && pos != PMAX) |=> (pos == POS_W'($past(pos) + 1'b1))); // R3
    AST_POS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_start && pos == PMAX) |=> (pos == PMAX));                 // R3
    AST_FIELD_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> odd);                                           // R8
    AST_LINE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !field_start) |=> (odd != $past(odd)));          // R8

endmodule

bind hblk_gen hblk_gen_chk #(
    .POS_W (POS_W),
    .NPH   (NPH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .field_start (field_start),
    .hblank      (hblank),
    .h_in        (h_in),
    .h_out       (h_out),
    .pos         (pos_now),
    .odd         (odd_now),
    .mask        (mask_now)
);

// File: tb/sim_hblk_gen.sv
module sim_hblk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        field_start = 1'b0;
    logic [3:0]  seq_sel = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_seq = '0;
    logic [2:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic [3:0]  h_in = '0;
    logic        hblank;
    logic [3:0]  h_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hblk_gen u0 (
        .clk, .rst_n, .line_start, .field_start, .seq_sel,
        .cfg_we, .cfg_seq, .cfg_addr, .cfg_wdata, .h_in, .hblank, .h_out
    );

    typedef struct packed {
        logic [1:0]  alt;
        logic [11:0] t1, t2, t3, t4, t5, t6;
        logic [31:0] exp_odd;
        logic [31:0] exp_even;
    } vec_t;

    // Expected hblank for positions 0..31, bit p = position p
    localparam vec_t VECS [6] = '{
        '{2'd0, 12'd2, 12'd5, 12'd8, 12'd10, 12'd20, 12'd24,   32'h00F0031C, 32'h00F0031C},
        '{2'd1, 12'd2, 12'd5, 12'd8, 12'd10, 12'd20, 12'd24,   32'h0000001C, 32'h00F00300},
        '{2'd2, 12'd2, 12'd5, 12'd8, 12'd10, 12'd20, 12'd24,   32'h00F00300, 32'h0000001C},
        '{2'd3, 12'd2, 12'd5, 12'd8, 12'd10, 12'd20, 12'd24,   32'h00F00300, 32'h0000001C},
        '{2'd0, 12'd0, 12'd1, 12'd12, 12'd6, 12'd30, 12'd31,   32'h40000001, 32'h40000001},
        '{2'd0, 12'd0, 12'd0, 12'd3, 12'd4, 12'd25, 12'd4095,  32'hFE000008, 32'hFE000008}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] s, input logic [2:0] a, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_seq = s; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_seq(input logic [3:0] s, input vec_t v, input logic mask);
        cfg_write(s, 3'd0, v.t1);
        cfg_write(s, 3'd1, v.t2);
        cfg_write(s, 3'd2, v.t3);
        cfg_write(s, 3'd3, v.t4);
        cfg_write(s, 3'd4, v.t5);
        cfg_write(s, 3'd5, v.t6);
        cfg_write(s, 3'd6, {9'd0, v.alt, mask});
    endtask

    // Returns at the negedge after the line-start edge (position 0)
    task automatic start_line(input logic fs);
        @(negedge clk);
        line_start = ~fs; field_start = fs;
        @(negedge clk);
        line_start = 1'b0; field_start = 1'b0;
    endtask

    // k-th following negedge shows the window result of position k-1
    task automatic capture(output logic [31:0] v);
        for (int p = 0; p < 32; p++) begin
            @(negedge clk);
            v[p] = hblank;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        vec_t tmp;

        // R1: reset state and idle before first line start
        h_in = 4'b0110;
        repeat (3) @(negedge clk);
        chk("R1 reset hblank", {31'd0, hblank}, 32'd0);
        chk("R1 reset pass", {28'd0, h_out}, {28'd0, h_in});
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 idle hblank", {31'd0, hblank}, 32'd0);
        chk("R1 idle pass", {28'd0, h_out}, 32'h6);
        h_in = 4'b0000;

        // Vector table: R4 windows, R5/R6/R7 alternation, R2 encoding
        for (int i = 0; i < 6; i++) begin
            string tag;
            tag = (i >= 4) ? "R4" : (VECS[i].alt == 2'd0) ? "R5" :
                  (VECS[i].alt == 2'd1) ? "R6" : "R7";
            program_seq(4'd0, VECS[i], 1'b0);
            seq_sel = 4'd0;
            start_line(1'b1);
            capture(got);
            chk({tag, " odd line R2"}, got, VECS[i].exp_odd);
            start_line(1'b0);
            capture(got);
            chk({tag, " even line"}, got, VECS[i].exp_even);
        end

        // R2: writes to sequence 10 or to address 7 are dropped
        cfg_write(4'd10, 3'd0, 12'd0);
        cfg_write(4'd10, 3'd1, 12'd31);
        cfg_write(4'd2, 3'd7, 12'd31);
        seq_sel = 4'd2;
        start_line(1'b1);
        capture(got);
        chk("R2 ignored writes", got, 32'h0);

        // R12: selection sampled only at line start
        tmp = '{2'd0, 12'd0, 12'd1, 12'd0, 12'd0, 12'd0, 12'd0, 32'h1, 32'h1};
        program_seq(4'd3, tmp, 1'b0);
        seq_sel = 4'd3;
        start_line(1'b1);
        seq_sel = 4'd0;
        capture(got);
        chk("R12 mid-line change", got, 32'h1);
        seq_sel = 4'd12;
        start_line(1'b0);
        capture(got);
        chk("R12 out-of-range keeps", got, 32'h1);

        // R9/R10/R11: phase parking
        program_seq(4'd0, VECS[0], 1'b1);
        program_seq(4'd4, VECS[0], 1'b0);
        seq_sel = 4'd0;
        start_line(1'b1);
        repeat (4) @(negedge clk);
        chk("R9 hblank inside", {31'd0, hblank}, 32'd1);
        h_in = 4'b0101; #1;
        chk("R9 park mask1", {28'd0, h_out}, 32'hA);
        h_in = 4'b1111; #1;
        chk("R9 park mask1 b", {28'd0, h_out}, 32'hA);
        repeat (2) @(negedge clk);
        h_in = 4'b1001; #1;
        chk("R11 pass outside", {28'd0, h_out}, 32'h9);
        seq_sel = 4'd4;
        start_line(1'b1);
        repeat (4) @(negedge clk);
        h_in = 4'b1010; #1;
        chk("R10 park mask0", {28'd0, h_out}, 32'h5);

        // R13: line start during blanking clears it
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk("R13 start clears", {31'd0, hblank}, 32'd0);
        h_in = 4'b0000;

        // R8: parity sequence odd, even, odd, even, then field -> odd
        tmp = '{2'd1, 12'd0, 12'd1, 12'd2, 12'd3, 12'd0, 12'd0, 32'h1, 32'h4};
        program_seq(4'd5, tmp, 1'b0);
        seq_sel = 4'd5;
        start_line(1'b1); capture(got); chk("R8 line1 odd", got, 32'h1);
        start_line(1'b0); capture(got); chk("R8 line2 even", got, 32'h4);
        start_line(1'b0); capture(got); chk("R8 line3 odd", got, 32'h1);
        start_line(1'b0); capture(got); chk("R8 line4 even", got, 32'h4);
        start_line(1'b1); capture(got); chk("R8 field resets odd", got, 32'h1);

        // R3: saturation at 4095 rather than wrap
        program_seq(4'd0, VECS[5], 1'b0);
        seq_sel = 4'd0;
        start_line(1'b1);
        repeat (4095) @(negedge clk);
        chk("R3 pos 4094 blank", {31'd0, hblank}, 32'd1);
        @(negedge clk);
        chk("R3 pos 4095 clear", {31'd0, hblank}, 32'd0);
        repeat (104) @(negedge clk);
        chk("R3 saturated", {31'd0, hblank}, 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule